// File: doc/BRIEF.md
# Auto-Incrementing Word Port into a Byte Buffer RAM

This block gives a host a single data port into a byte-organized buffer RAM that holds two logical lists: an isochronous list buffer and an acknowledged list buffer. The host first programs a transfer length in bytes. It then writes one command code, which picks the list and the direction. After that it moves any number of 16-bit words through the data port without sending the command again. Each word carries two RAM bytes. The two lists place those bytes in opposite halves of the word.

An internal byte pointer starts at the beginning of the chosen list when a command arrives. It steps by two on every accepted word. When the pointer reaches the programmed length, the block raises a one-cycle end-of-transfer pulse, sets a sticky interrupt bit and marks the list as done in a status register. Further word accesses are ignored until the next command. When the length is odd, the final word moves only its low-address byte.

All registers sit on a small synchronous host bus with separate write and read strobes. Reads return data one cycle after the strobe. The RAM behind the port is synchronous, with one enable per byte lane.

Top module: `wbuf_word_port`

## Requirements
- R1: A command write (register address 0, code in data bits 7:0) decodes 0x40 as isochronous read, 0xC0 as isochronous write, 0x41 as acknowledged read and 0xC1 as acknowledged write. Any other code is ignored, and a transfer in progress continues unchanged.
- R2: A valid command sets the byte pointer to the start of the selected list and latches the length register (address 1) as the transfer length. It also clears that list's done bit. The words that follow need no further command.
- R3: Each accepted word access advances the pointer by two bytes, so consecutive words reach consecutive byte pairs.
- R4: On the isochronous list, data bits 15:8 carry the even-address byte and bits 7:0 carry the odd-address byte.
- R5: On the acknowledged list, data bits 15:8 carry the odd-address byte and bits 7:0 carry the even-address byte.
- R6: When the pointer after an access reaches or passes the transfer length, `eot_pulse` is high for exactly the one cycle after that access.
- R7: End of transfer sets bit 2 of the interrupt register (address 3), and `irq` follows that bit. The bit stays set until the host writes 1 to bit 2. If a set and a clear arrive in the same cycle, the set wins.
- R8: End of transfer sets bit 0 (isochronous) or bit 1 (acknowledged) of the buffer status register (address 4).
- R9: With an odd length, the final word moves only the even-address byte. A write leaves the odd byte in RAM unchanged, and a read returns 0x00 in the odd byte's lane.
- R10: The block ignores a data port access (address 2) in three cases: after end of transfer, when its direction differs from the command, or when the length is zero. An ignored access moves no pointer, changes no RAM byte and raises no end of transfer. An ignored read returns the last word read from RAM.
- R11: After reset, the data port reads 0x0000, the interrupt and status registers read 0, and `irq` and `eot_pulse` are low.
- R12: A read strobe yields `host_rvalid` in the next cycle with the register value: the last valid command code at address 0 and the length register at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe; takes priority over a read in the same cycle |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register select: 0 command, 1 length, 2 data port, 3 interrupt, 4 status |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| eot_pulse | output | 1 | One-cycle end-of-transfer event |
| irq | output | 1 | Sticky end-of-transfer interrupt |

## Verification
The bench builds the block with BUF_BYTES=16 and LEN_W=16. With a 16-byte list, both lists fit in a small bench model, and a full-list transfer takes only eight words. Odd lengths of 3 and 5 bring the half-word final access within reach on both lists. The difference between the two lane orders then shows up in which RAM byte survives a half-word write. Using the same parameters for write and read-back transfers of differing lengths exposes pointer, length-latch and lane-swap faults as data mismatches.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int REG_AW = 3;

    typedef enum logic {
        LIST_ISO = 1'b0,
        LIST_ACK = 1'b1
    } list_e;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    // Command codes: bit 7 selects direction, bit 0 selects the list
    localparam logic [7:0] CODE_ISO_RD = 8'h40;
    localparam logic [7:0] CODE_ISO_WR = 8'hC0;
    localparam logic [7:0] CODE_ACK_RD = 8'h41;
    localparam logic [7:0] CODE_ACK_WR = 8'hC1;

    // Host register map
    localparam logic [REG_AW-1:0] RA_CMD  = 3'd0;
    localparam logic [REG_AW-1:0] RA_LEN  = 3'd1;
    localparam logic [REG_AW-1:0] RA_DATA = 3'd2;
    localparam logic [REG_AW-1:0] RA_INT  = 3'd3;
    localparam logic [REG_AW-1:0] RA_STAT = 3'd4;

    localparam int INT_EOT_BIT = 2;

endpackage

// File: rtl/wbp_cmd_decode.sv
module wbp_cmd_decode
    import wbp_pkg::*;
(
    input  logic [7:0] code,
    output logic       valid,
    output list_e      list,
    output dir_e       dir
);

    always_comb begin
        valid = 1'b1;
        list  = LIST_ISO;
        dir   = DIR_RD;
        case (code)
            CODE_ISO_RD: begin
                list = LIST_ISO;
                dir  = DIR_RD;
            end
            CODE_ISO_WR: begin
                list = LIST_ISO;
                dir  = DIR_WR;
            end
            CODE_ACK_RD: begin
                list = LIST_ACK;
                dir  = DIR_RD;
            end
            CODE_ACK_WR: begin
                list = LIST_ACK;
                dir  = DIR_WR;
            end
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/wbp_byte_ram.sv
module wbp_byte_ram
    import wbp_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic                   clk,
    input  logic [AW-1:0]          addr,
    input  logic [1:0]             we,
    input  logic [1:0][BYTE_W-1:0] wbyte,
    output logic [1:0][BYTE_W-1:0] rbyte
);

    // Lane 0 holds even-address bytes, lane 1 odd-address bytes
    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [BYTE_W-1:0] bank [WORDS];
        logic [BYTE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we[l]) begin
                bank[addr] <= wbyte[l];
            end
            rd_q <= bank[addr];
        end

        assign rbyte[l] = rd_q;
    end

endmodule

// File: rtl/wbp_lane_map.sv
module wbp_lane_map
    import wbp_pkg::*;
(
    input  list_e                  wr_list,
    input  logic [WORD_W-1:0]      wr_word,
    output logic [1:0][BYTE_W-1:0] wr_bytes,
    input  list_e                  rd_list,
    input  logic                   rd_odd_ok,
    input  logic [1:0][BYTE_W-1:0] rd_bytes,
    output logic [WORD_W-1:0]      rd_word
);

    logic [BYTE_W-1:0] odd_b;

    always_comb begin
        if (wr_list == LIST_ISO) begin
            wr_bytes[0] = wr_word[15:8];
            wr_bytes[1] = wr_word[7:0];
        end else begin
            wr_bytes[0] = wr_word[7:0];
            wr_bytes[1] = wr_word[15:8];
        end
    end

    always_comb begin
        odd_b = rd_odd_ok ? rd_bytes[1] : '0;
        if (rd_list == LIST_ISO) begin
            rd_word = {rd_bytes[0], odd_b};
        end else begin
            rd_word = {odd_b, rd_bytes[0]};
        end
    end

endmodule

// File: rtl/wbuf_word_port.sv
module wbuf_word_port
    import wbp_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int LEN_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [REG_AW-1:0]   host_addr,
    input  logic [WORD_W-1:0]   host_wdata,
    output logic [WORD_W-1:0]   host_rdata,
    output logic                host_rvalid,
    output logic                eot_pulse,
    output logic                irq
);

    localparam int PTR_W     = LEN_W + 1;
    localparam int OFF_HI    = $clog2(BUF_BYTES) - 1;
    localparam int RAM_WORDS = BUF_BYTES;
    localparam int RAM_AW    = $clog2(RAM_WORDS);

    typedef struct packed {
        list_e             list;
        dir_e              dir;
        logic              active;
        logic [PTR_W-1:0]  ptr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  len_reg;
        logic [7:0]        cmd;
        logic              int_eot;
        logic [1:0]        done;
        logic              eot;
        logic              rvalid;
        logic              rd_ram;
        list_e             rd_list;
        logic              rd_half;
        logic [WORD_W-1:0] rreg;
        logic [WORD_W-1:0] dword;
    } st_t;

    st_t st_d, st_q;

    logic                   dec_valid;
    list_e                  dec_list;
    dir_e                   dec_dir;
    logic [1:0][BYTE_W-1:0] wr_bytes;
    logic [1:0][BYTE_W-1:0] rd_bytes;
    logic [WORD_W-1:0]      rd_word;
    logic [RAM_AW-1:0]      ram_addr;
    logic [1:0]             ram_we;
    logic                   acc_wr, acc_rd, acc_any;
    logic                   half, last;
    logic [PTR_W-1:0]       step;
    logic                   rd_strobe;

    wbp_cmd_decode u_dec (
        .code  (host_wdata[7:0]),
        .valid (dec_valid),
        .list  (dec_list),
        .dir   (dec_dir)
    );

    wbp_lane_map u_map (
        .wr_list   (st_q.list),
        .wr_word   (host_wdata),
        .wr_bytes  (wr_bytes),
        .rd_list   (st_q.rd_list),
        .rd_odd_ok (~st_q.rd_half),
        .rd_bytes  (rd_bytes),
        .rd_word   (rd_word)
    );

    wbp_byte_ram #(.WORDS(RAM_WORDS)) u_ram (
        .clk   (clk),
        .addr  (ram_addr),
        .we    (ram_we),
        .wbyte (wr_bytes),
        .rbyte (rd_bytes)
    );

    // Access qualification and pointer arithmetic
    always_comb begin
        rd_strobe = host_rd && !host_wr;
        acc_wr    = host_wr && (host_addr == RA_DATA) && st_q.active && (st_q.dir == DIR_WR);
        acc_rd    = rd_strobe && (host_addr == RA_DATA) && st_q.active && (st_q.dir == DIR_RD);
        acc_any   = acc_wr || acc_rd;
        step      = st_q.ptr + PTR_W'(2);
        half      = (st_q.ptr + PTR_W'(1)) == {1'b0, st_q.len};
        last      = step >= {1'b0, st_q.len};
        ram_addr  = {st_q.list, st_q.ptr[OFF_HI:1]};
        ram_we    = {acc_wr && !half, acc_wr};
    end

    // Next-state computation
    always_comb begin
        st_d        = st_q;
        st_d.eot    = 1'b0;
        st_d.rvalid = 1'b0;
        st_d.rd_ram = 1'b0;

        if (st_q.rd_ram) begin
            st_d.dword = rd_word;
        end

        if (host_wr && (host_addr == RA_LEN)) begin
            st_d.len_reg = host_wdata[LEN_W-1:0];
        end

        if (host_wr && (host_addr == RA_CMD) && dec_valid) begin
            st_d.cmd            = host_wdata[7:0];
            st_d.list           = dec_list;
            st_d.dir            = dec_dir;
            st_d.ptr            = '0;
            st_d.len            = st_q.len_reg;
            st_d.active         = (st_q.len_reg != '0);
            st_d.done[dec_list] = 1'b0;
        end

        if (host_wr && (host_addr == RA_INT) && host_wdata[INT_EOT_BIT]) begin
            st_d.int_eot = 1'b0;
        end

        if (acc_any) begin
            st_d.ptr = step;
            if (last) begin
                st_d.active          = 1'b0;
                st_d.eot             = 1'b1;
                st_d.int_eot         = 1'b1;
                st_d.done[st_q.list] = 1'b1;
            end
        end

        if (rd_strobe) begin
            st_d.rvalid  = 1'b1;
            st_d.rd_ram  = acc_rd;
            st_d.rd_list = st_q.list;
            st_d.rd_half = half;
            case (host_addr)
                RA_CMD:  st_d.rreg = {8'h00, st_q.cmd};
                RA_LEN:  st_d.rreg = WORD_W'(st_q.len_reg);
                RA_DATA: st_d.rreg = st_q.rd_ram ? rd_word : st_q.dword;
                RA_INT:  st_d.rreg = WORD_W'({st_q.int_eot, 2'b00});
                RA_STAT: st_d.rreg = WORD_W'(st_q.done);
                default: st_d.rreg = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{
                list:    LIST_ISO,
                dir:     DIR_RD,
                active:  1'b0,
                ptr:     '0,
                len:     '0,
                len_reg: '0,
                cmd:     '0,
                int_eot: 1'b0,
                done:    '0,
                eot:     1'b0,
                rvalid:  1'b0,
                rd_ram:  1'b0,
                rd_list: LIST_ISO,
                rd_half: 1'b0,
                rreg:    '0,
                dword:   '0
            };
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata  = st_q.rd_ram ? rd_word : st_q.rreg;
    assign host_rvalid = st_q.rvalid;
    assign eot_pulse   = st_q.eot;
    assign irq         = st_q.int_eot;

    // Observation points for the bound checker
    logic             xfer_active;
    logic [PTR_W-1:0] xfer_ptr;
    assign xfer_active = st_q.active;
    assign xfer_ptr    = st_q.ptr;

endmodule

// File: rtl/wbp_checker.sv
module wbp_checker
    import wbp_pkg::*;
#(
    parameter int PTR_W = 17
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic               host_rd,
    input logic [REG_AW-1:0]  host_addr,
    input logic [WORD_W-1:0]  host_wdata,
    input logic               host_rvalid,
    input logic               eot_pulse,
    input logic               irq,
    input logic               acc_any,
    input logic               xfer_active,
    input logic [PTR_W-1:0]   xfer_ptr
);

    logic int_clr;
    assign int_clr = host_wr && (host_addr == RA_INT) && host_wdata[INT_EOT_BIT];

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_any |=> (xfer_ptr == $past(xfer_ptr) + PTR_W'(2))); // R3

    AST_EOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eot_pulse |=> !eot_pulse); // R6

    AST_EOT_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        eot_pulse |-> irq); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !int_clr) |=> irq); // R7

    AST_EOT_ENDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        eot_pulse |-> !xfer_active); // R10

    AST_IDLE_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && !(host_wr && host_addr == RA_CMD)) |=> $stable(xfer_ptr)); // R10

    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> host_rvalid); // R12

    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr) |=> !host_rvalid); // R12

endmodule

bind wbuf_word_port wbp_checker #(.PTR_W(PTR_W)) u_wbp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rvalid (host_rvalid),
    .eot_pulse   (eot_pulse),
    .irq         (irq),
    .acc_any     (acc_any),
    .xfer_active (xfer_active),
    .xfer_ptr    (xfer_ptr)
);

// File: tb/test_wbuf_word_port.sv
module test_wbuf_word_port;
    import wbp_pkg::*;

    localparam int BUF_BYTES = 16;
    localparam int LEN_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [REG_AW-1:0] host_addr = '0;
    logic [15:0]       host_wdata = '0;
    logic [15:0]       host_rdata;
    logic              host_rvalid;
    logic              eot_pulse;
    logic              irq;

    always #2 clk = ~clk;

    wbuf_word_port #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) i_wbuf_word_port (
        .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata,
        .host_rdata, .host_rvalid, .eot_pulse, .irq
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Scoreboard queues
    logic [15:0] exp_q[$];
    string       tag_q[$];

    // Requirement-level model
    logic [7:0]  mem_m [2*BUF_BYTES];
    bit          m_list, m_dir, m_active;
    int          m_ptr, m_len, m_lenreg;
    logic [15:0] m_last;

    task automatic check_eq(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expectations as read data appears
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R12 unexpected rvalid: actual %h expected none", host_rdata);
            end else begin
                check_eq(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [REG_AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [REG_AW-1:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_len(input int n);
        m_lenreg = n;
        bus_write(RA_LEN, 16'(n));
    endtask

    task automatic command(input logic [7:0] code);
        if (code == 8'h40 || code == 8'hC0 || code == 8'h41 || code == 8'hC1) begin
            m_list = code[0]; m_dir = code[7];
            m_ptr = 0; m_len = m_lenreg; m_active = (m_lenreg != 0);
        end
        bus_write(RA_CMD, {8'h00, code});
    endtask

    task automatic word_wr(input logic [15:0] w, input string tag);
        bit e = 0;
        if (m_active && m_dir) begin
            int base = m_list * BUF_BYTES + (m_ptr % BUF_BYTES);
            bit hf = (m_ptr + 1 == m_len);
            mem_m[base] = m_list ? w[7:0] : w[15:8];
            if (!hf) mem_m[base+1] = m_list ? w[15:8] : w[7:0];
            m_ptr += 2;
            if (m_ptr >= m_len) begin e = 1; m_active = 0; end
        end
        bus_write(RA_DATA, w);
        check_eq({tag, " R6 eot after write"}, {15'b0, eot_pulse}, {15'b0, e});
    endtask

    task automatic word_rd(input string tag);
        bit e = 0;
        logic [15:0] x = m_last;
        if (m_active && !m_dir) begin
            int base = m_list * BUF_BYTES + (m_ptr % BUF_BYTES);
            bit hf = (m_ptr + 1 == m_len);
            logic [7:0] ev = mem_m[base];
            logic [7:0] od = hf ? 8'h00 : mem_m[base+1];
            x = m_list ? {od, ev} : {ev, od};
            m_last = x;
            m_ptr += 2;
            if (m_ptr >= m_len) begin e = 1; m_active = 0; end
        end
        bus_read(RA_DATA, x, tag);
        check_eq({tag, " R6 eot after read"}, {15'b0, eot_pulse}, {15'b0, e});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        m_list = 0; m_dir = 0; m_active = 0; m_ptr = 0; m_len = 0; m_lenreg = 0; m_last = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        check_eq("R11 irq after reset", {15'b0, irq}, 16'h0);
        check_eq("R11 eot after reset", {15'b0, eot_pulse}, 16'h0);
        bus_read(RA_DATA, 16'h0000, "R11 data port reset");
        bus_read(RA_INT,  16'h0000, "R11 interrupt reset");
        bus_read(RA_STAT, 16'h0000, "R11 status reset");

        // Isochronous write of 8 bytes, R4 R3 R2
        set_len(8);
        bus_read(RA_LEN, 16'h0008, "R12 length readback");
        command(8'hC0);
        bus_read(RA_CMD, 16'h00C0, "R12 command readback");
        word_wr(16'hA1B2, "R3");
        word_wr(16'hC3D4, "R3");
        word_wr(16'hE5F6, "R3");
        word_wr(16'h0718, "R6 last word");
        @(negedge clk);
        check_eq("R6 eot single cycle", {15'b0, eot_pulse}, 16'h0);
        check_eq("R7 irq set by eot", {15'b0, irq}, 16'h1);
        bus_read(RA_INT,  16'h0004, "R7 interrupt bit 2");
        bus_read(RA_STAT, 16'h0001, "R8 isochronous done");

        // R10 write after end of transfer is ignored
        word_wr(16'hFFFF, "R10 post-eot write");

        // Isochronous read back, R4 mapping, R1 invalid code mid-transfer
        command(8'h40);
        bus_read(RA_STAT, 16'h0000, "R2 done cleared by command");
        word_rd("R4 word0");
        word_rd("R4 word1");
        bus_write(RA_CMD, 16'h0042);
        bus_read(RA_CMD, 16'h0040, "R1 invalid code not latched");
        word_rd("R1 transfer continues");
        word_rd("R4 word3");
        word_rd("R10 read after eot holds last word");

        // R7 write-one-to-clear
        bus_write(RA_INT, 16'h0000);
        bus_read(RA_INT, 16'h0004, "R7 write zero keeps bit");
        bus_write(RA_INT, 16'h0004);
        bus_read(RA_INT, 16'h0000, "R7 write one clears bit");
        check_eq("R7 irq cleared", {15'b0, irq}, 16'h0);

        // Acknowledged list, R5 mapping, R9 odd length
        set_len(6);
        command(8'hC1);
        word_wr(16'h1122, "R5");
        word_wr(16'h3344, "R5");
        word_wr(16'h5566, "R5");
        set_len(5);
        command(8'hC1);
        word_wr(16'hAAAA, "R5");
        word_wr(16'hBBBB, "R5");
        word_wr(16'hCCDD, "R9 half word ack");
        bus_read(RA_STAT, 16'h0003, "R8 both lists done");
        set_len(6);
        command(8'h41);
        word_rd("R5 ack word0");
        word_wr(16'h9999, "R10 wrong direction");
        word_rd("R5 ack word1");
        word_rd("R9 ack odd byte kept");

        // Isochronous odd length
        set_len(3);
        command(8'hC0);
        word_wr(16'h1357, "R4");
        word_wr(16'h2468, "R9 half word iso");
        set_len(4);
        command(8'h40);
        word_rd("R9 iso word0");
        word_rd("R9 iso odd byte kept");
        set_len(3);
        command(8'h40);
        word_rd("R9 iso word0");
        word_rd("R9 odd lane reads zero");

        // R10 zero length
        set_len(0);
        command(8'hC0);
        word_wr(16'h7777, "R10 zero length");
        set_len(2);
        command(8'h40);
        word_rd("R10 zero length left RAM unchanged");

        repeat (3) @(negedge clk);
        check_eq("R12 all reads answered", 16'(exp_q.size()), 16'h0);
        summary();
        $finish;
    end

endmodule